// File: doc/BRIEF.md
# Sample Clock Generator with Minimum-Width Transmit Shaper

This block turns the fast crystal clock into a one-cycle sample strobe whose period is picked by a 3-bit rate selector. On every strobe it also takes one sample of the raw asynchronous transmit line and produces a conditioned copy. The conditioned copy guarantees that a level lasts long enough for the compression stage that follows, which needs each data level to span a minimum number of sample periods. The fastest usable bit rate is therefore the sample rate divided by that minimum of ten.

A level that is already wide enough passes through one sample late. A level that is too short is held until it has spanned ten samples, and then the output follows the input. Stretching is bounded: after three stretched levels in a row, further short levels pass unmodified until a naturally long level has been seen. The strobe works as the valid qualifier for the shaped level. There is no ready signal, because a serial line level cannot be held back, so the consumer must take the level on every strobe.

When the selector's top bit is not brought out (parameter `RATE_MSB_PRESENT` = 0), that bit is taken as 1.

Top module: `sample_shaper_top`

## Requirements
- R1: The strobe period in clock cycles follows the selector: 3'b011 gives 160, 3'b100 gives 80, 3'b101 gives 40, 3'b110 gives 20 and 3'b111 gives 15.
- R2: Selector values 3'b000, 3'b001 and 3'b010 give a period of 160 clock cycles.
- R3: `samp_stb` is high for exactly one cycle per period. After reset is released, the first strobe is high in the cycle that follows the period-th rising edge.
- R4: While `rst_n` is low at a rising edge, `samp_stb` becomes 0 and `tx_shaped` becomes 1, and the shaper returns to its idle state. In the idle state the output counts as a long level and no stretch run is in progress.
- R5: `tx_shaped` changes only at a rising edge where `samp_stb` is high.
- R6: If the output level has already lasted 10 or more samples and the sampled input differs from it, the output takes the input value at that same edge.
- R7: If the sampled input differs from an output level that has lasted fewer than 10 samples, and fewer than three stretched levels precede it in the current run, the output holds its level until it has lasted 10 samples.
- R8: Once three stretched levels have run back to back, a short input level is passed through at once without stretching.
- R9: A level that lasts 10 or more samples without stretching clears the stretch run, so the next short level is stretched again.
- R10: A sampled input equal to the current output leaves the output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rate_sel | input | 3 | Sample-period selector |
| tx_raw | input | 1 | Raw asynchronous transmit level |
| samp_stb | output | 1 | One-cycle sample strobe, also the valid for `tx_shaped` |
| tx_shaped | output | 1 | Conditioned transmit level, idle high |

## Verification
Two events can land on the same strobe edge: a stretch ending because the held level has reached ten samples, and a fresh input transition. At that edge the shaper must both switch the output and advance the stretch run. The same happens when the run limit is reached and a short level arrives on the very sample that would otherwise have started a fourth stretch. Runs of one- to three-sample pulses, mixed with random level lengths, push these cases onto shared edges. Each edge is judged against a sample-level model that tracks the output level, its age and the run count.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int unsigned DIV_SLOWEST = 160;
  localparam int unsigned DIV_SLOW    = 80;
  localparam int unsigned DIV_MID     = 40;
  localparam int unsigned DIV_FAST    = 20;
  localparam int unsigned DIV_FASTEST = 15;
  localparam int unsigned CNT_W       = $clog2(DIV_SLOWEST);

  typedef logic [2:0]       rate_sel_t;
  typedef logic [CNT_W-1:0] div_cnt_t;

  // terminal count (period - 1) for a selector value
  function automatic div_cnt_t term_of(rate_sel_t sel);
    case (sel)
      3'b100:  return div_cnt_t'(DIV_SLOW - 1);
      3'b101:  return div_cnt_t'(DIV_MID - 1);
      3'b110:  return div_cnt_t'(DIV_FAST - 1);
      3'b111:  return div_cnt_t'(DIV_FASTEST - 1);
      default: return div_cnt_t'(DIV_SLOWEST - 1);
    endcase
  endfunction
endpackage

// File: rtl/sc_rate_div.sv
module sc_rate_div
  import sc_pkg::*;
#(
  parameter bit RATE_MSB_PRESENT = 1'b1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  rate_sel_t rate_sel,
  output logic      samp_stb
);
  rate_sel_t eff_sel;
  div_cnt_t  cnt;
  div_cnt_t  term;

  generate
    if (RATE_MSB_PRESENT) begin : g_full_sel
      assign eff_sel = rate_sel;
    end else begin : g_msb_tied
      assign eff_sel = {1'b1, rate_sel[1:0]};
    end
  endgenerate

  assign term = term_of(eff_sel);

  // a count at or past the terminal wraps, so a selector change settles within one period
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      samp_stb <= 1'b0;
    end else if (cnt >= term) begin
      cnt      <= '0;
      samp_stb <= 1'b1;
    end else begin
      cnt      <= cnt + 1'b1;
      samp_stb <= 1'b0;
    end
  end
endmodule

// File: rtl/sc_pulse_shaper.sv
module sc_pulse_shaper #(
  parameter int unsigned MIN_SAMPLES = 10,
  parameter int unsigned MAX_RUN     = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic samp_stb,
  input  logic tx_raw,
  output logic tx_shaped
);
  localparam int unsigned HOLD_W = $clog2(MIN_SAMPLES + 1);
  localparam int unsigned RUN_W  = $clog2(MAX_RUN + 1);
  localparam logic [HOLD_W-1:0] HOLD_FULL = HOLD_W'(MIN_SAMPLES);
  localparam logic [RUN_W-1:0]  RUN_FULL  = RUN_W'(MAX_RUN);

  logic [HOLD_W-1:0] hold;     // samples the current output level has lasted (saturating)
  logic [RUN_W-1:0]  run;      // stretched levels in the current run
  logic              stretched; // current output level is being or was extended

  logic differs, level_long, may_stretch;
  assign differs     = (tx_raw != tx_shaped);
  assign level_long  = (hold >= HOLD_FULL);
  assign may_stretch = (run < RUN_FULL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_shaped <= 1'b1;
      hold      <= HOLD_FULL;
      run       <= '0;
      stretched <= 1'b0;
    end else if (samp_stb) begin
      if (differs && level_long) begin
        tx_shaped <= tx_raw;
        hold      <= HOLD_W'(1);
        stretched <= 1'b0;
        if (stretched)
          run <= may_stretch ? run + 1'b1 : RUN_FULL;
        else
          run <= '0;
      end else if (differs && may_stretch) begin
        stretched <= 1'b1;
        hold      <= hold + 1'b1;
      end else if (differs) begin
        tx_shaped <= tx_raw;
        hold      <= HOLD_W'(1);
        stretched <= 1'b0;
      end else if (!level_long) begin
        hold <= hold + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sample_shaper_top.sv
module sample_shaper_top #(
  parameter bit          RATE_MSB_PRESENT = 1'b1,
  parameter int unsigned MIN_SAMPLES      = 10,
  parameter int unsigned MAX_RUN          = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] rate_sel,
  input  logic       tx_raw,
  output logic       samp_stb,
  output logic       tx_shaped
);
  sc_rate_div #(.RATE_MSB_PRESENT(RATE_MSB_PRESENT)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .rate_sel (rate_sel),
    .samp_stb (samp_stb)
  );

  sc_pulse_shaper #(.MIN_SAMPLES(MIN_SAMPLES), .MAX_RUN(MAX_RUN)) u_shape (
    .clk       (clk),
    .rst_n     (rst_n),
    .samp_stb  (samp_stb),
    .tx_raw    (tx_raw),
    .tx_shaped (tx_shaped)
  );
endmodule

// File: rtl/sample_shaper_chk.sv
module sample_shaper_chk #(
  parameter int unsigned MIN_SAMPLES = 10
) (
  input logic clk,
  input logic rst_n,
  input logic tx_raw,
  input logic samp_stb,
  input logic tx_shaped
);
  localparam int unsigned AGE_W = $clog2(MIN_SAMPLES + 1);
  logic [AGE_W-1:0] age;
  logic             prev_y;

  // independent age of the output level, counted in strobes
  always_ff @(posedge clk) begin
    prev_y <= rst_n ? tx_shaped : 1'b1;
    if (!rst_n)
      age <= AGE_W'(MIN_SAMPLES);
    else if (tx_shaped != prev_y)
      age <= AGE_W'(1);
    else if (samp_stb && age < AGE_W'(MIN_SAMPLES))
      age <= age + 1'b1;
  end

  // R3
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    samp_stb |=> !samp_stb);

  // R4
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (tx_shaped && !samp_stb));

  // R5
  change_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !samp_stb |=> $stable(tx_shaped));

  // R10
  equal_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_stb && tx_raw == tx_shaped) |=> $stable(tx_shaped));

  // R6
  long_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_stb && tx_raw != tx_shaped && age >= AGE_W'(MIN_SAMPLES)) |=> (tx_shaped == $past(tx_raw)));
endmodule

bind sample_shaper_top sample_shaper_chk #(.MIN_SAMPLES(MIN_SAMPLES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tx_raw    (tx_raw),
  .samp_stb  (samp_stb),
  .tx_shaped (tx_shaped)
);

// File: tb/sim_sample_shaper_top.sv
module sim_sample_shaper_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] rate_sel = 3'b111;
  logic       tx_raw = 1'b1;
  logic       samp_stb, tx_shaped;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // model state
  bit m_y = 1'b1;
  int m_hold = 10;
  int m_run = 0;
  bit m_str = 1'b0;
  string m_tag;

  always #5 clk = ~clk;

  sample_shaper_top u0 (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .tx_raw(tx_raw),
    .samp_stb(samp_stb), .tx_shaped(tx_shaped)
  );

  function automatic int exp_period(logic [2:0] c);
    case (c)
      3'b011:  return 160;
      3'b100:  return 80;
      3'b101:  return 40;
      3'b110:  return 20;
      3'b111:  return 15;
      default: return 160;
    endcase
  endfunction

  function automatic void model_reset();
    m_y = 1'b1; m_hold = 10; m_run = 0; m_str = 1'b0;
  endfunction

  function automatic void model_step(bit s);
    if (s != m_y) begin
      if (m_hold >= 10) begin
        if (m_str) begin m_run = (m_run < 3) ? m_run + 1 : 3; m_tag = "R6"; end
        else begin m_tag = (m_run != 0) ? "R9" : "R6"; m_run = 0; end
        m_y = s; m_hold = 1; m_str = 1'b0;
      end else if (m_run < 3) begin
        m_str = 1'b1; m_hold++; m_tag = "R7";
      end else begin
        m_y = s; m_hold = 1; m_str = 1'b0; m_tag = "R8";
      end
    end else begin
      if (m_hold < 10) m_hold++;
      m_tag = "R10";
    end
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic apply_sample(bit v);
    @(negedge clk);
    while (!samp_stb) @(negedge clk);
    check(tx_shaped == m_y, "R5", tx_shaped, m_y);
    tx_raw = v;
    model_step(v);
    @(negedge clk);
    check(tx_shaped == m_y, m_tag, tx_shaped, m_y);
  endtask

  task automatic apply_level(bit v, int n);
    for (int i = 0; i < n; i++) apply_sample(v);
  endtask

  task automatic chk_period(logic [2:0] c, string req);
    int n;
    @(negedge clk);
    rate_sel = c;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      while (!samp_stb) @(negedge clk);
    end
    n = 0;
    do begin @(negedge clk); n++; end while (!samp_stb);
    check(n == exp_period(c), req, n, exp_period(c));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    tx_raw = 1'b1;
    repeat (2) @(negedge clk);
    check(tx_shaped == 1'b1, "R4", tx_shaped, 1);
    check(samp_stb == 1'b0, "R4", samp_stb, 0);
    model_reset();
    rst_n = 1'b1;
  endtask

  initial begin
    int n;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(tx_shaped == 1'b1, "R4", tx_shaped, 1);
    check(samp_stb == 1'b0, "R4", samp_stb, 0);
    // first strobe after release, at rate 111
    rst_n = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!samp_stb);
    check(n == 15, "R3", n, 15);
    @(negedge clk);
    check(samp_stb == 1'b0, "R3", samp_stb, 0);

    // periods for every selector value
    chk_period(3'b011, "R1");
    chk_period(3'b100, "R1");
    chk_period(3'b101, "R1");
    chk_period(3'b110, "R1");
    chk_period(3'b111, "R1");
    chk_period(3'b000, "R2");
    chk_period(3'b001, "R2");
    chk_period(3'b010, "R2");
    chk_period(3'b111, "R1");

    // long levels pass with one-sample latency
    apply_level(1'b1, 3);
    apply_level(1'b0, 12);
    apply_level(1'b1, 10);
    // short pulses: three stretched, then pass-through
    for (int i = 0; i < 6; i++) apply_level(i[0] ? 1'b1 : 1'b0, 2);
    apply_level(1'b0, 1);
    apply_level(1'b1, 1);
    // long level clears the run, then a short one is stretched again
    apply_level(1'b0, 14);
    apply_level(1'b1, 2);
    apply_level(1'b0, 12);

    // reset in mid-level
    apply_level(1'b0, 3);
    do_reset();

    // random levels at several rates
    for (int seg = 0; seg < 4; seg++) begin
      rate_sel = (seg == 2) ? 3'b110 : 3'b111;
      for (int j = 0; j < 60; j++)
        apply_level(1'($urandom % 2), 1 + int'($urandom % 14));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule